// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs from one input clock. A plain memory-mapped register port (address, write data, write strobe, combinational read data) sets each channel's enable, output polarity, drive-type flag, 16-bit period count, 16-bit duty count and 6-bit clock prescaler. Each enabled channel divides the clock by its prescale value plus one and steps a period counter. The output is in its active phase while that counter is below the duty count.

Period, duty and prescale writes go to shadow copies. A running channel adopts them only when its current period wraps, so it never emits a truncated or stretched cycle. A disabled channel adopts them at once. Every change of a channel's effective enable opens a settling window, and a further enable change requested inside that window waits until the window has closed.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000F00 (all enables 0, all polarity bits 1, all drive-type bits 0). Period, duty and prescale words read 0. All PWM pins are low and all drive-type outputs are 0.
- R2: Register map. The control word is at 0x00, with enable of channel n at bit n, polarity at bit 8+n and drive type at bit 15+n. Period of channel n is at 0x04+8n and duty at 0x08+8n, both using bits 15:0. Prescale is at 0x24, with channel n's 6-bit field at bits (3-n)*6+5:(3-n)*6, so channel 0 is at 23:18. Reads return the last value written to the defined bits. Undefined bits and unmapped addresses read 0.
- R3: drive_type_o[n] equals control bit 15+n from the clock edge that writes it.
- R4: Take the first clock edge at which a channel is effectively enabled. From the cycle after that edge, the output repeats with a period of (prescale+1)*period_count cycles. It is active for the first (prescale+1)*duty_count cycles of each period.
- R5: Polarity bit 1 makes the active level high, and 0 makes it low. A disabled channel drives the inactive level of its current polarity.
- R6: A duty count greater than or equal to the period count holds the output active. A duty count of 0 holds it inactive.
- R7: Period, duty and prescale writes to an enabled channel take effect at the first period wrap after the write edge. Writes to a disabled channel are in force from the first period after enabling.
- R8: An enable bit change takes effect one clock after its write edge. Each effective enable change starts a hold of SETTLE_CYC cycles, and a request made during the hold is applied at edge SETTLE_CYC+1 after the previous change.
- R9: Re-enabling a channel restarts its waveform at the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for counters and registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| pwm_o | output | NUM_CH | PWM pins, one per channel |
| drive_type_o | output | NUM_CH | Per-channel drive-type flag (0 = push-pull) |

## Verification
Register writes land at the write edge, so read data and drive-type outputs are checked in the low phase right after it. A control write changes the effective enable one edge later. Pin levels are therefore predicted from that effective edge, or from the end of the settling window when a hold applies, plus the prescaled period formula. A shadowed period change is predicted from the first wrap edge strictly after the write edge. The driver computes these edge numbers from the write edge number it records, then queues one expected pin vector per edge number. The monitor compares each vector in the low phase of the clock that carries that edge number.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

   // Byte offsets of the register words
   localparam int unsigned CTRL_OFS   = 0;
   localparam int unsigned PER_OFS    = 4;
   localparam int unsigned DUTY_OFS   = 8;
   localparam int unsigned CH_STRIDE  = 8;
   localparam int unsigned PSC_OFS    = 36;

   // Field placement inside the control word
   localparam int unsigned EN_LSB     = 0;
   localparam int unsigned POL_LSB    = 8;
   localparam int unsigned TYPE_LSB   = 15;

   // Number of prescale slots packed in the prescale word (slot 0 on top)
   localparam int unsigned PSC_SLOTS  = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_PSC,
      SEL_PER,
      SEL_DUTY
   } reg_sel_e;

endpackage

// File: rtl/mpwm_regfile.sv
module mpwm_regfile
   import mpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 6,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   input  logic                             we_i,
   output logic [DATA_W-1:0]                rdata_o,
   output logic [NUM_CH-1:0]                en_req_o,
   output logic [NUM_CH-1:0]                pol_o,
   output logic [NUM_CH-1:0]                drv_o,
   output logic [NUM_CH-1:0][CNT_W-1:0]     per_o,
   output logic [NUM_CH-1:0][CNT_W-1:0]     duty_o,
   output logic [NUM_CH-1:0][PSC_W-1:0]     psc_o
);

   localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned PSC_TOP = PSC_SLOTS * PSC_W;

   if (NUM_CH > PSC_SLOTS) begin : g_bad_nch
      $fatal(1, "NUM_CH exceeds prescale slots");
   end
   if (NUM_CH > POL_LSB - EN_LSB || POL_LSB + NUM_CH > TYPE_LSB) begin : g_bad_ctrl
      $fatal(1, "control fields overlap");
   end
   if (DATA_W <= PSC_TOP || DATA_W < TYPE_LSB + NUM_CH || DATA_W < CNT_W) begin : g_bad_dw
      $fatal(1, "DATA_W too narrow for the register map");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $fatal(1, "ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0]            en_q, pol_q, drv_q;
   logic [NUM_CH-1:0][CNT_W-1:0] per_q, duty_q;
   logic [NUM_CH-1:0][PSC_W-1:0] psc_q;
   reg_sel_e                     sel;
   logic [CH_W-1:0]              sel_ch;
   logic                         unused_wdata;

   assign unused_wdata = ^wdata_i[DATA_W-1:PSC_TOP];

   // Address decode
   always_comb begin
      sel    = SEL_NONE;
      sel_ch = '0;
      if (addr_i == ADDR_W'(CTRL_OFS)) sel = SEL_CTRL;
      if (addr_i == ADDR_W'(PSC_OFS))  sel = SEL_PSC;
      for (int n = 0; n < NUM_CH; n++) begin
         if (addr_i == ADDR_W'(PER_OFS + CH_STRIDE * n)) begin
            sel    = SEL_PER;
            sel_ch = CH_W'(n);
         end
         if (addr_i == ADDR_W'(DUTY_OFS + CH_STRIDE * n)) begin
            sel    = SEL_DUTY;
            sel_ch = CH_W'(n);
         end
      end
   end

   // Storage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         pol_q  <= '1;
         drv_q  <= '0;
         per_q  <= '0;
         duty_q <= '0;
         psc_q  <= '0;
      end else if (we_i) begin
         case (sel)
            SEL_CTRL: begin
               en_q  <= wdata_i[EN_LSB   +: NUM_CH];
               pol_q <= wdata_i[POL_LSB  +: NUM_CH];
               drv_q <= wdata_i[TYPE_LSB +: NUM_CH];
            end
            SEL_PSC: begin
               for (int n = 0; n < NUM_CH; n++) begin
                  psc_q[n] <= wdata_i[(PSC_SLOTS - 1 - n) * PSC_W +: PSC_W];
               end
            end
            SEL_PER:  per_q[sel_ch]  <= wdata_i[CNT_W-1:0];
            SEL_DUTY: duty_q[sel_ch] <= wdata_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // Read mux
   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_CTRL: begin
            rdata_o[EN_LSB   +: NUM_CH] = en_q;
            rdata_o[POL_LSB  +: NUM_CH] = pol_q;
            rdata_o[TYPE_LSB +: NUM_CH] = drv_q;
         end
         SEL_PSC: begin
            for (int n = 0; n < NUM_CH; n++) begin
               rdata_o[(PSC_SLOTS - 1 - n) * PSC_W +: PSC_W] = psc_q[n];
            end
         end
         SEL_PER:  rdata_o[CNT_W-1:0] = per_q[sel_ch];
         SEL_DUTY: rdata_o[CNT_W-1:0] = duty_q[sel_ch];
         default: ;
      endcase
   end

   assign en_req_o = en_q;
   assign pol_o    = pol_q;
   assign drv_o    = drv_q;
   assign per_o    = per_q;
   assign duty_o   = duty_q;
   assign psc_o    = psc_q;

endmodule

// File: rtl/mpwm_en_guard.sv
module mpwm_en_guard #(
   parameter int unsigned SETTLE_CYC = 40
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic en_o
);

   localparam int unsigned HW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

   logic en_q;

   if (SETTLE_CYC == 0) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) en_q <= 1'b0;
         else         en_q <= req_i;
      end
   end else begin : g_hold
      logic [HW-1:0] hold_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q   <= 1'b0;
            hold_q <= '0;
         end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
         end else if (req_i != en_q) begin
            en_q   <= req_i;
            hold_q <= HW'(SETTLE_CYC);
         end
      end

      // R8: no enable change while the settling window is open
      p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hold_q != '0) |=> (en_q == $past(en_q)));

      // R8: an idle guard adopts a differing request on the next edge and opens a window
      p_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hold_q == '0 && req_i != en_q) |=> (en_q == $past(req_i) && hold_q == HW'(SETTLE_CYC)));
   end

   assign en_o = en_q;

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PSC_W   = 6,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             pwm_o
);

   if (CNT_W < 2 || PSC_W < 1) begin : g_bad_w
      $fatal(1, "counter widths too small");
   end

   logic [CNT_W-1:0] per_act, duty_act, per_cnt;
   logic [PSC_W-1:0] psc_act, psc_cnt;
   logic             tick, wrap, load, active, lvl;

   assign tick   = (psc_cnt == psc_act);
   assign wrap   = tick && (({1'b0, per_cnt} + (CNT_W + 1)'(1)) >= {1'b0, per_act});
   assign load   = !en_i || wrap;
   assign active = en_i && (per_cnt < duty_act);
   assign lvl    = pol_i ? active : !active;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         psc_cnt  <= '0;
         per_cnt  <= '0;
         per_act  <= '0;
         duty_act <= '0;
         psc_act  <= '0;
      end else begin
         if (!en_i) begin
            psc_cnt <= '0;
            per_cnt <= '0;
         end else if (tick) begin
            psc_cnt <= '0;
            per_cnt <= wrap ? '0 : per_cnt + CNT_W'(1);
         end else begin
            psc_cnt <= psc_cnt + PSC_W'(1);
         end
         if (load) begin
            per_act  <= per_i;
            duty_act <= duty_i;
            psc_act  <= psc_i;
         end
      end
   end

   if (OUT_REG) begin : g_out_flop
      logic pwm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pwm_q <= 1'b0;
         else         pwm_q <= lvl;
      end
      assign pwm_o = pwm_q;
   end else begin : g_out_comb
      assign pwm_o = lvl;
   end

   // R4: the period counter never reaches the active period count
   p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_act != '0) |-> (per_cnt < per_act));

   // R5: a disabled channel parks both counters at zero
   p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (per_cnt == '0 && psc_cnt == '0));

   // R7: active settings only move at a period wrap or while disabled
   p_shadow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !wrap) |=> (per_act == $past(per_act) && duty_act == $past(duty_act)
                           && psc_act == $past(psc_act)));

endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PSC_W      = 6,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SETTLE_CYC = 40,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_we_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CH-1:0] pwm_o,
   output logic [NUM_CH-1:0] drive_type_o
);

   logic [NUM_CH-1:0]            en_req, en_eff, pol;
   logic [NUM_CH-1:0][CNT_W-1:0] per_sh, duty_sh;
   logic [NUM_CH-1:0][PSC_W-1:0] psc_sh;

   mpwm_regfile #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .PSC_W  (PSC_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .we_i     (bus_we_i),
      .rdata_o  (bus_rdata_o),
      .en_req_o (en_req),
      .pol_o    (pol),
      .drv_o    (drive_type_o),
      .per_o    (per_sh),
      .duty_o   (duty_sh),
      .psc_o    (psc_sh)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mpwm_en_guard #(
         .SETTLE_CYC (SETTLE_CYC)
      ) u_guard (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .req_i  (en_req[c]),
         .en_o   (en_eff[c])
      );

      mpwm_chan #(
         .CNT_W   (CNT_W),
         .PSC_W   (PSC_W),
         .OUT_REG (OUT_REG)
      ) u_chan (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (en_eff[c]),
         .pol_i  (pol[c]),
         .per_i  (per_sh[c]),
         .duty_i (duty_sh[c]),
         .psc_i  (psc_sh[c]),
         .pwm_o  (pwm_o[c])
      );
   end

endmodule

// File: tb/quad_pwm_ctrl_tb_top.sv
module quad_pwm_ctrl_tb_top;

   localparam int NCH    = 4;
   localparam int AW     = 6;
   localparam int DW     = 32;
   localparam int SETTLE = 40;
   localparam int NEVER  = 32'h7fff_ffff;
   localparam logic [AW-1:0] A_CTRL = 6'h00;
   localparam logic [AW-1:0] A_PSC  = 6'h24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [DW-1:0]  wdata = '0;
   logic           we = 1'b0;
   logic [DW-1:0]  rdata;
   logic [NCH-1:0] pins, drv;

   quad_pwm_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_addr_i   (addr),
      .bus_wdata_i  (wdata),
      .bus_we_i     (we),
      .bus_rdata_o  (rdata),
      .pwm_o        (pins),
      .drive_type_o (drv)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Bus driver: returns the edge number at which the write landed
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int edge_no);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      edge_no = cyc;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic logic [AW-1:0] per_a(int n);
      return AW'(4 + 8 * n);
   endfunction

   function automatic logic [AW-1:0] duty_a(int n);
      return AW'(8 + 8 * n);
   endfunction

   // Reference model state, built from the requirements
   int   m_per[NCH], m_duty[NCH], m_psc[NCH], m_base[NCH];
   int   m_from[NCH], m_until[NCH], m_sw_t[NCH], m_sw_per[NCH];
   logic m_pol[NCH];

   function automatic logic [NCH-1:0] model(int t);
      logic [NCH-1:0] r;
      for (int c = 0; c < NCH; c++) begin
         int   b;
         int   p;
         logic act;
         b = m_base[c];
         p = m_per[c];
         if (t >= m_sw_t[c]) begin
            b = m_sw_t[c];
            p = m_sw_per[c];
         end
         if (t >= m_from[c] && t < m_until[c])
            act = (((t - b) / (m_psc[c] + 1)) % p) < m_duty[c];
         else
            act = 1'b0;
         r[c] = m_pol[c] ? act : !act;
      end
      return r;
   endfunction

   // Scoreboard
   typedef struct {
      int             t;
      logic [NCH-1:0] pins;
      string          req;
   } exp_t;

   exp_t sbq[$];
   exp_t cur;

   task automatic push_win(input int t0, input int n, input string req);
      for (int k = 0; k < n; k++) begin
         exp_t it;
         it.t    = t0 + k;
         it.pins = model(t0 + k);
         it.req  = req;
         sbq.push_back(it);
      end
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].t <= cyc) begin
         cur = sbq.pop_front();
         if (cur.t < cyc) chk(cur.req, 64'(cur.t), 64'(cyc), "missed sample slot");
         else             chk(cur.req, 64'(pins), 64'(cur.pins), $sformatf("pins at edge %0d", cyc));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [DW-1:0] d;
      int w1, w2, w3, wc, wx, wy, e, off1, on2, bnd, tmp;

      for (int c = 0; c < NCH; c++) begin
         m_sw_t[c] = NEVER; m_sw_per[c] = 1; m_from[c] = NEVER; m_until[c] = NEVER;
         m_base[c] = 0; m_per[c] = 1; m_duty[c] = 0; m_psc[c] = 0; m_pol[c] = 1'b1;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(A_CTRL, d); chk("R1", d, 32'h0000_0F00, "ctrl after reset");
      for (int n = 0; n < NCH; n++) begin
         rd(per_a(n), d);  chk("R1", d, 0, $sformatf("period %0d after reset", n));
         rd(duty_a(n), d); chk("R1", d, 0, $sformatf("duty %0d after reset", n));
      end
      rd(A_PSC, d); chk("R1", d, 0, "prescale after reset");
      chk("R1", pins, 0, "pins after reset");
      chk("R1", drv, 0, "drive type after reset");

      // R2 / R3: map, masking, unmapped reads, drive-type output
      wr(A_CTRL, 32'hFFFF_FFF0, tmp);
      chk("R3", drv, 4'hF, "drive type after write");
      rd(A_CTRL, d); chk("R2", d, 32'h0007_8F00, "ctrl masked readback");
      chk("R5", pins, 0, "disabled pins, normal polarity");
      wr(per_a(0), 32'hABCD_1234, tmp);
      rd(per_a(0), d); chk("R2", d, 32'h0000_1234, "period low half only");
      wr(A_PSC, 32'hFFFF_FFFF, tmp);
      rd(A_PSC, d); chk("R2", d, 32'h00FF_FFFF, "prescale masked readback");
      wr(6'h28, 32'hFFFF_FFFF, tmp);
      rd(6'h28, d); chk("R2", d, 0, "unmapped address");

      // Configuration: ch0 P5 D2 psc1; ch1 P4 D6; ch2 P3 D1 psc2 inverted; ch3 P4 D0
      wr(A_CTRL, 32'h0000_0B00, tmp);
      chk("R3", drv, 0, "drive type cleared");
      chk("R5", pins, 4'b0100, "disabled pins, ch2 inverted");
      wr(A_PSC, 32'h0004_0080, tmp);
      rd(A_PSC, d); chk("R2", d, 32'h0004_0080, "prescale fields ch0 top, ch2 mid");
      wr(per_a(0), 5, tmp); wr(duty_a(0), 2, tmp);
      wr(per_a(1), 4, tmp); wr(duty_a(1), 6, tmp);
      wr(per_a(2), 3, tmp); wr(duty_a(2), 1, tmp);
      wr(per_a(3), 4, tmp); wr(duty_a(3), 0, tmp);
      rd(duty_a(1), d); chk("R2", d, 6, "duty ch1 readback");
      m_per  = '{5, 4, 3, 4};
      m_duty = '{2, 6, 1, 0};
      m_psc  = '{1, 0, 2, 0};
      m_pol  = '{1'b1, 1'b1, 1'b0, 1'b1};

      // R4 R6 R8: enable all, then request ch1 off inside the settle window
      wr(A_CTRL, 32'h0000_0B0F, w1);
      e = w1 + 1;
      wr(A_CTRL, 32'h0000_0B0D, w2);
      off1 = (w2 + 1 > e + SETTLE + 1) ? w2 + 1 : e + SETTLE + 1;
      for (int c = 0; c < NCH; c++) begin
         m_from[c] = e; m_base[c] = e; m_until[c] = NEVER;
      end
      m_until[1] = off1;
      push_win(w2 + 1, 70, "R4 R5 R6 R8");
      drain();

      // R7: shadowed period change on ch0; R8 R9: ch1 re-enable held off
      wr(per_a(0), 3, wc);
      bnd = e + ((wc - e) / 10 + 1) * 10;
      rd(per_a(0), d); chk("R7", d, 3, "period shadow readback");
      wr(A_CTRL, 32'h0000_0B0F, w3);
      on2 = (w3 + 1 > off1 + SETTLE + 1) ? w3 + 1 : off1 + SETTLE + 1;
      m_sw_t[0] = bnd; m_sw_per[0] = 3;
      m_from[1] = on2; m_base[1] = on2; m_until[1] = NEVER;
      push_win(w3 + 1, 80, "R7 R8 R9");
      drain();

      // R7: writes while disabled are used from the first period; R9 restart
      wr(A_CTRL, 32'h0000_0B0E, wx);
      wr(per_a(0), 4, tmp);
      wr(A_PSC, 32'h0000_0080, tmp);
      chk("R5", pins[0], 1'b0, "ch0 disabled level");
      repeat (SETTLE + 10) @(negedge clk);
      wr(A_CTRL, 32'h0000_0B0F, wy);
      m_from[0] = wy + 1; m_base[0] = wy + 1; m_until[0] = NEVER;
      m_per[0] = 4; m_psc[0] = 0; m_sw_t[0] = NEVER;
      push_win(wy + 1, 40, "R7 R9");
      drain();

      finish_up();
   end

endmodule